// File: doc/BRIEF.md
# Digest ICV Check and Completion Reporter

This block sits at the tail of a hash execution unit. When the hash core strobes that a job is done, the block compares the freshly computed digest with a reference integrity check value (ICV). The comparison covers a programmable number of leading bytes. The block then tells the host about the job's completion and about the ICV outcome through exactly one channel: a status writeback request or an interrupt.

Three reporting modes follow from the configuration inputs. If either writeback-enable bit is set, the block uses writeback mode. In that mode every completion issues a writeback request, and the ICV result travels in the written status fields. If both writeback-enable bits are clear and the ICV error interrupt is unmasked, the block uses interrupt mode. In that mode a mismatch replaces the normal completion with an error interrupt. If both writeback-enable bits are clear and the error interrupt is masked, the block uses silent mode. In that mode a mismatch only sets the sticky status bit.

Any accepted mismatch sets a sticky error status bit. While that bit is set, the block ignores further done strobes until the host clears the bit.

Top module: `icv_report_ctrl`

## Requirements
- R1: Byte k of a digest occupies bits [8k+7:8k]. Byte k takes part in the comparison only when k is less than the length input. A length of 64 or more compares all 64 bytes, and a length of 0 compares none, which always passes.
- R2: When the check enable input is low, the block never reports a mismatch, whatever the two digests hold.
- R3: In writeback mode (either writeback-enable bit set), each accepted strobe produces a write request and a done interrupt. The failure field is 1 exactly on a mismatch, and the checked field equals the check enable. The error interrupt is never raised in this mode, even when it is unmasked.
- R4: In interrupt mode (both writeback-enable bits clear, error interrupt unmasked), a passing job produces only a done interrupt.
- R5: In interrupt mode, a mismatching job produces only an error interrupt. No done interrupt and no write request are issued.
- R6: In silent mode (both writeback-enable bits clear, error interrupt masked), a mismatching job produces a done interrupt and sets the status bit, with no error interrupt.
- R7: Every accepted mismatch sets the error status bit. The bit stays set until a cycle with the clear input high, and it reads 0 from the cycle after that clear.
- R8: A done strobe that arrives while the status bit is set is ignored. It produces no output pulse and leaves the status bit unchanged.
- R9: All outputs are registered and read 0 out of reset. Each pulse appears in the cycle after its done strobe and lasts a single cycle.
- R10: The done and error interrupts are never high together, and the error interrupt and the write request are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_strobe_i | input | 1 | One-cycle job-complete strobe from the hash core |
| check_en_i | input | 1 | Enables the ICV comparison for this job |
| computed_icv_i | input | 512 | Digest produced by the hash core |
| reference_icv_i | input | 512 | Supplied ICV to compare against |
| icv_len_i | input | 7 | Number of leading bytes compared |
| wb_cfg_a_i | input | 1 | First writeback-enable bit |
| wb_cfg_b_i | input | 1 | Second writeback-enable bit |
| icv_err_mask_i | input | 1 | 1 masks the ICV error interrupt |
| err_clr_i | input | 1 | Write-one-to-clear of the error status bit |
| done_irq_o | output | 1 | Job-done interrupt pulse |
| err_irq_o | output | 1 | ICV error interrupt pulse |
| wb_req_o | output | 1 | Status writeback request pulse |
| wb_icv_fail_o | output | 1 | Status field: ICV mismatch, valid with wb_req_o |
| wb_icv_checked_o | output | 1 | Status field: ICV check was performed, valid with wb_req_o |
| err_status_o | output | 1 | Sticky ICV error status |

## Verification
The hardest situation to reach from the ports is a done strobe that arrives while the sticky error bit is still set, especially when the clear arrives in the same cycle. The stimulus reaches it in steps. It first forces an interrupt-mode mismatch, then offers a passing job without clearing, and finally pairs a strobe with the clear, expecting that strobe to be dropped. The length boundary is probed by flipping single bytes just inside and just outside the compared region, including the zero-length case and lengths above 64.

// File: rtl/icv_rpt_pkg.sv
// Package: shared types for the ICV check and completion reporter.
// Assumes: the three reporting modes are fully decided by the two
// writeback-enable bits and the error interrupt mask.
package icv_rpt_pkg;

    typedef enum logic [1:0] {
        RPT_SILENT    = 2'd0,
        RPT_IRQ       = 2'd1,
        RPT_WRITEBACK = 2'd2
    } rpt_mode_e;

    typedef struct packed {
        logic done_irq;
        logic err_irq;
        logic wb_req;
        logic wb_fail;
        logic wb_checked;
    } rpt_out_t;

    // Writeback wins over any interrupt setting; otherwise the mask decides.
    function automatic rpt_mode_e decode_mode(input logic wb_a,
                                              input logic wb_b,
                                              input logic err_mask);
        if (wb_a || wb_b)
            return RPT_WRITEBACK;
        else if (!err_mask)
            return RPT_IRQ;
        else
            return RPT_SILENT;
    endfunction

endpackage

// File: rtl/icv_byte_cmp.sv
// Module: byte-granular, length-limited digest comparator.
// Compares the leading LEN bytes of two digests (byte k at bits [8k+7:8k])
// and flags a mismatch only when checking is enabled.
// Assumes: purely combinational; the caller registers the result.
module icv_byte_cmp #(
    parameter int BYTES = 64,
    parameter int LEN_W = $clog2(BYTES + 1)
) (
    input  logic [BYTES*8-1:0] computed_i,
    input  logic [BYTES*8-1:0] reference_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               check_en_i,
    output logic               mismatch_o
);

    logic [BYTES-1:0] byte_diff;

    // One comparator per byte, qualified by the length window.
    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        localparam logic [31:0] IDX = 32'(k);
        logic in_window;
        assign in_window    = (32'(len_i) > IDX);
        assign byte_diff[k] = in_window &&
                              (computed_i[8*k +: 8] != reference_i[8*k +: 8]);
    end

    // Reduce the per-byte flags and gate with the check enable.
    always_comb begin
        mismatch_o = check_en_i && (|byte_diff);
    end

endmodule

// File: rtl/icv_route.sv
// Module: decides which completion and error pulses a finished job produces
// and registers them, together with the writeback status fields.
// Assumes: accept_i is already gated by the sticky error status.
module icv_route
    import icv_rpt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept_i,
    input  logic      mismatch_i,
    input  logic      check_en_i,
    input  rpt_mode_e mode_i,
    output rpt_out_t  out_o
);

    rpt_out_t nxt;
    rpt_out_t q;

    // Map the mode and compare outcome onto the output pulses.
    always_comb begin
        nxt = '0;
        if (accept_i) begin
            unique case (mode_i)
                RPT_WRITEBACK: begin
                    nxt.done_irq   = 1'b1;
                    nxt.wb_req     = 1'b1;
                    nxt.wb_fail    = mismatch_i;
                    nxt.wb_checked = check_en_i;
                end
                RPT_IRQ: begin
                    nxt.done_irq = !mismatch_i;
                    nxt.err_irq  = mismatch_i;
                end
                default: begin
                    nxt.done_irq = 1'b1;
                end
            endcase
        end
    end

    // Register every output so each pulse lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    assign out_o = q;

    // R10
    // done_err_excl_chk
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.done_irq && q.err_irq));

    // R10
    // err_wb_excl_chk
    err_wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.err_irq && q.wb_req));

    // R9
    // pulse_source_chk
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done_irq || q.err_irq || q.wb_req) |-> $past(accept_i));

    // R3
    // wb_mode_chk
    wb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wb_req |-> $past(mode_i == RPT_WRITEBACK));

endmodule

// File: rtl/icv_err_flag.sv
// Module: sticky ICV error status with a write-one-to-clear input.
// Assumes: a set and a clear in the same cycle resolve to set.
module icv_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Hold the error until the host clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R7
    // flag_clear_chk
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/icv_report_ctrl.sv
// Module: top of the ICV check and completion reporter.
// Compares the computed digest with the reference on each accepted done
// strobe, then reports through writeback, interrupt or the status bit only.
// Assumes: done_strobe_i is a one-cycle pulse from the hash core.
module icv_report_ctrl
    import icv_rpt_pkg::*;
#(
    parameter int DIGEST_BYTES = 64,
    localparam int DW    = DIGEST_BYTES * 8,
    localparam int LEN_W = $clog2(DIGEST_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_strobe_i,
    input  logic             check_en_i,
    input  logic [DW-1:0]    computed_icv_i,
    input  logic [DW-1:0]    reference_icv_i,
    input  logic [LEN_W-1:0] icv_len_i,
    input  logic             wb_cfg_a_i,
    input  logic             wb_cfg_b_i,
    input  logic             icv_err_mask_i,
    input  logic             err_clr_i,
    output logic             done_irq_o,
    output logic             err_irq_o,
    output logic             wb_req_o,
    output logic             wb_icv_fail_o,
    output logic             wb_icv_checked_o,
    output logic             err_status_o
);

    logic      mismatch;
    logic      accept;
    logic      err_flag;
    rpt_mode_e mode;
    rpt_out_t  rpt;

    // Decode the reporting mode from configuration.
    always_comb begin
        mode = decode_mode(wb_cfg_a_i, wb_cfg_b_i, icv_err_mask_i);
    end

    // Drop strobes while a previous error is still pending.
    always_comb begin
        accept = done_strobe_i && !err_flag;
    end

    icv_byte_cmp #(
        .BYTES (DIGEST_BYTES),
        .LEN_W (LEN_W)
    ) cmp_i (
        .computed_i  (computed_icv_i),
        .reference_i (reference_icv_i),
        .len_i       (icv_len_i),
        .check_en_i  (check_en_i),
        .mismatch_o  (mismatch)
    );

    icv_route route_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .mismatch_i (mismatch),
        .check_en_i (check_en_i),
        .mode_i     (mode),
        .out_o      (rpt)
    );

    icv_err_flag flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (accept && mismatch),
        .clr_i  (err_clr_i),
        .flag_o (err_flag)
    );

    assign done_irq_o       = rpt.done_irq;
    assign err_irq_o        = rpt.err_irq;
    assign wb_req_o         = rpt.wb_req;
    assign wb_icv_fail_o    = rpt.wb_fail;
    assign wb_icv_checked_o = rpt.wb_checked;
    assign err_status_o     = err_flag;

    // R8
    // blocked_strobe_chk
    blocked_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_strobe_i && err_status_o) |=>
            !(done_irq_o || err_irq_o || wb_req_o));

    // R8
    // blocked_status_chk
    blocked_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_strobe_i && err_status_o && !err_clr_i) |=> err_status_o);

    // R7
    // err_implies_status_chk
    err_implies_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |-> err_status_o);

    // R3
    // wb_cfg_chk
    wb_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o |-> $past(wb_cfg_a_i || wb_cfg_b_i));

endmodule

// File: tb/icv_report_ctrl_tb_top.sv
module icv_report_ctrl_tb_top;

    localparam int BYTES = 64;
    localparam int DW    = BYTES * 8;
    localparam int NV    = 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          strobe, ce, wba, wbb, msk, clr;
    logic [DW-1:0] comp, refv;
    logic [6:0]    len;
    logic          done_irq, err_irq, wb_req, wb_fail, wb_chk, err_st;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    icv_report_ctrl dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .done_strobe_i    (strobe),
        .check_en_i       (ce),
        .computed_icv_i   (comp),
        .reference_icv_i  (refv),
        .icv_len_i        (len),
        .wb_cfg_a_i       (wba),
        .wb_cfg_b_i       (wbb),
        .icv_err_mask_i   (msk),
        .err_clr_i        (clr),
        .done_irq_o       (done_irq),
        .err_irq_o        (err_irq),
        .wb_req_o         (wb_req),
        .wb_icv_fail_o    (wb_fail),
        .wb_icv_checked_o (wb_chk),
        .err_status_o     (err_st)
    );

    // Fields: ce wba wbb msk len[7] flip_idx[7] | exp done err wb fail status
    localparam logic [22:0] VECS [0:NV-1] = '{
        {1'b1,1'b0,1'b0,1'b0,7'd64, 7'd127, 5'b10000},
        {1'b1,1'b0,1'b0,1'b0,7'd64, 7'd5,   5'b01001},
        {1'b1,1'b1,1'b0,1'b1,7'd64, 7'd5,   5'b10111},
        {1'b1,1'b0,1'b1,1'b1,7'd64, 7'd127, 5'b10100},
        {1'b1,1'b0,1'b0,1'b1,7'd64, 7'd0,   5'b10001},
        {1'b1,1'b0,1'b0,1'b0,7'd16, 7'd16,  5'b10000},
        {1'b1,1'b0,1'b0,1'b0,7'd16, 7'd15,  5'b01001},
        {1'b0,1'b0,1'b0,1'b0,7'd64, 7'd3,   5'b10000},
        {1'b1,1'b1,1'b1,1'b0,7'd32, 7'd40,  5'b10100},
        {1'b1,1'b1,1'b0,1'b0,7'd1,  7'd0,   5'b10111},
        {1'b1,1'b0,1'b0,1'b0,7'd1,  7'd1,   5'b10000},
        {1'b0,1'b1,1'b0,1'b1,7'd8,  7'd0,   5'b10100},
        {1'b1,1'b0,1'b0,1'b0,7'd0,  7'd0,   5'b10000},
        {1'b1,1'b0,1'b0,1'b0,7'd100,7'd63,  5'b01001}
    };

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] flipped(input logic [6:0] idx);
        logic [DW-1:0] m;
        m = '0;
        if (idx < 7'd64) m[8*idx] = 1'b1;
        return refv ^ m;
    endfunction

    task automatic launch(input logic c, a, b, m, input logic [6:0] l,
                          input logic [6:0] idx);
        @(negedge clk);
        ce = c; wba = a; wbb = b; msk = m; len = l;
        comp = flipped(idx);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic clear_status();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; strobe = 1'b0; ce = 1'b0; wba = 1'b0; wbb = 1'b0;
        msk = 1'b0; clr = 1'b0; len = 7'd64;
        refv = {16{32'h5AC3_9E17}};
        comp = refv;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset outputs", {done_irq, err_irq, wb_req, wb_fail, wb_chk, err_st}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            logic [22:0] e;
            e = VECS[v];
            launch(e[22], e[21], e[20], e[19], e[18:12], e[11:5]);
            chk($sformatf("R4/R6 done_irq vec %0d", v), done_irq, e[4]);
            chk($sformatf("R5 err_irq vec %0d", v), err_irq, e[3]);
            chk($sformatf("R3 wb_req vec %0d", v), wb_req, e[2]);
            chk($sformatf("R1/R2 wb_fail vec %0d", v), wb_fail, e[1]);
            chk($sformatf("R3 wb_checked vec %0d", v), wb_chk, e[2] & e[22]);
            chk($sformatf("R7 status vec %0d", v), err_st, e[0]);
            @(negedge clk);
            // R9: pulse lasts one cycle
            chk($sformatf("R9 single pulse vec %0d", v), {done_irq, err_irq, wb_req}, 0);
            clear_status();
            chk($sformatf("R7 cleared vec %0d", v), err_st, 1'b0);
        end

        // R8: strobe while status set is ignored
        launch(1'b1, 1'b0, 1'b0, 1'b0, 7'd64, 7'd9);
        chk("R5 err_irq before hold-off", err_irq, 1'b1);
        launch(1'b1, 1'b1, 1'b0, 1'b1, 7'd64, 7'd127);
        chk("R8 blocked outputs", {done_irq, err_irq, wb_req}, 0);
        chk("R8 status kept", err_st, 1'b1);
        repeat (5) @(negedge clk);
        chk("R7 status sticky idle", err_st, 1'b1);

        // R8: strobe paired with clear is still dropped
        @(negedge clk);
        clr = 1'b1; strobe = 1'b1; comp = refv; wba = 1'b0; msk = 1'b0;
        @(negedge clk);
        clr = 1'b0; strobe = 1'b0;
        chk("R8 strobe with clear dropped", {done_irq, err_irq, wb_req}, 0);
        chk("R7 clear takes effect", err_st, 1'b0);

        // R4: next passing strobe is accepted again
        launch(1'b1, 1'b0, 1'b0, 1'b0, 7'd64, 7'd127);
        chk("R4 accepted after clear", {done_irq, err_irq, wb_req}, 3'b100);

        // R9: back-to-back strobes produce back-to-back pulses
        @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        chk("R9 first of pair", done_irq, 1'b1);
        @(negedge clk);
        strobe = 1'b0;
        chk("R9 second of pair", done_irq, 1'b1);
        @(negedge clk);
        chk("R9 pair ends", done_irq, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule